// File: doc/BRIEF.md
# I2C Bus Status and Interrupt Generator

This block listens to the clock and data lines of an I2C bus, in the role of a simple byte-oriented slave, and turns what it sees into a small set of sticky status flags and one level interrupt request. Each line first passes through a multi-flop synchronizer and a glitch filter that run on the system clock. From the cleaned levels the block detects START and STOP conditions, counts clock rises within each byte, and flags byte completion, address reception, the acknowledge bit after a transmitted byte, stop reception and misplaced bus conditions. Each flag is set at a fixed cycle relative to the bus edge that causes it.

Firmware or a neighbouring controller picks the data direction through a transmit/receive input and acknowledges events with a one-cycle clear strobe. The block does not drive either bus line. It does not stretch the clock and it does not hold the data shift register. The captured acknowledge bit is kept on its own output.

Top module: `i2c_stat_gen`

## Requirements
- R1: After reset every status flag, the captured acknowledge value and the interrupt request are 0.
- R2: In receive mode (`tx_mode_i`=0), the byte-complete flag sets on the 8th SCL rise after a START. It becomes visible after the 5th system-clock rising edge that follows the SCL input rise (4 edges of synchronizer and filter, 1 edge to register). SCL rises with no START since the last STOP are not counted.
- R3: In transmit mode (`tx_mode_i`=1), a data byte completes on the 9th SCL rise (8 bits plus acknowledge) rather than on the 8th.
- R4: The first byte after a START is an address byte. It completes on its 8th SCL rise whatever the direction, and the address flag sets in the same cycle as byte-complete.
- R5: In transmit mode, the 9th SCL rise of a data byte sets the LRB flag together with byte-complete and copies filtered SDA into `lrb_val_o` (0 = ACK, 1 = NACK). `lrb_val_o` holds its value through clear strobes.
- R6: SDA rising while SCL is high sets the stop flag after the 6th system-clock edge that follows the SDA input change.
- R7: A START or STOP detected once two or more SCL rises of the current byte have been counted sets the bus-error flag, with the same timing as R6. A condition at a byte boundary, including one inside the high phase of the first clock of a byte, does not set it.
- R8: Flags stay set until `clr_i` is high for a clock edge. That edge clears all of them unless a new event sets a flag in the same cycle, in which case the new event wins.
- R9: `irq_o` is high exactly while at least one status flag is set.
- R10: A level that holds for only one system clock on a bus input is rejected by the filter and is not counted as an SCL rise.
- R11: A repeated START at a byte boundary raises no bus error, restarts the bit count and makes the next byte an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| tx_mode_i | input | 1 | 1 = slave transmits data bytes, 0 = slave receives |
| clr_i | input | 1 | One-cycle strobe that clears all status flags |
| st_bc_o | output | 1 | Byte-complete flag |
| st_addr_o | output | 1 | Address-byte flag |
| st_lrb_o | output | 1 | Acknowledge-captured flag |
| st_stop_o | output | 1 | Stop-received flag |
| st_berr_o | output | 1 | Misplaced START/STOP flag |
| lrb_val_o | output | 1 | Last acknowledge bit sampled after a transmitted byte |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a two-flop synchronizer, a filter that needs two equal samples, and eight-bit bytes. With these values the exact edges in R2, R6 and R7 can be checked against fixed cycle counts. The same settings make a single-cycle input pulse the longest glitch that must be rejected, and they put the 8th/9th clock split and the misplaced-condition window at known bit positions the bench can reach. A vector table walks address and data bytes in both directions, including repeated starts. Directed tests then probe edge timing, glitches and misplaced conditions.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  typedef struct packed {
    logic berr;
    logic stop;
    logic lrb;
    logic addr;
    logic bc;
  } stat_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 1,
  parameter logic RST_VAL     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   lvl_q;
  logic                   synced;
  logic                   stable;

  assign synced = sync_q[SYNC_STAGES-1];
  assign stable = (hist_q == {FILT_LEN{synced}});

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {SYNC_STAGES{RST_VAL}};
      lvl_q  <= RST_VAL;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      if (stable) lvl_q <= synced;
    end
  end

  generate
    if (FILT_LEN == 1) begin : g_hist_one
      always_ff @(posedge clk) begin
        if (rst) hist_q <= {FILT_LEN{RST_VAL}};
        else     hist_q <= synced;
      end
    end else begin : g_hist_many
      always_ff @(posedge clk) begin
        if (rst) hist_q <= {FILT_LEN{RST_VAL}};
        else     hist_q <= {hist_q[FILT_LEN-2:0], synced};
      end
    end
  endgenerate

  assign dout = lvl_q;
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic start_q,
  output logic stop_q
);
  logic scl_p, sda_p;
  logic start_c, stop_c;

  assign scl_rise = scl_f & ~scl_p;
  assign start_c  = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_c   = scl_f & scl_p & ~sda_p & sda_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p   <= 1'b1;
      sda_p   <= 1'b1;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      scl_p   <= scl_f;
      sda_p   <= sda_f;
      start_q <= start_c;
      stop_q  <= stop_c;
    end
  end
endmodule

// File: rtl/i2c_bit_tracker.sv
module i2c_bit_tracker #(
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_rise,
  input  logic start_q,
  input  logic stop_q,
  input  logic tx_mode,
  input  logic sda_f,
  output logic set_bc,
  output logic set_addr,
  output logic set_lrb,
  output logic lrb_bit,
  output logic set_stop,
  output logic set_berr
);
  localparam int CNT_W = $clog2(BYTE_BITS + 2);
  localparam logic [CNT_W-1:0] PT_DATA = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] PT_ACK  = CNT_W'(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] PT_MID  = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, cnt_nx, bc_pt;
  logic             addr_pend_q, active_q;
  logic             rise_act;

  assign cnt_nx   = cnt_q + 1'b1;
  assign rise_act = active_q & scl_rise;
  assign bc_pt    = (addr_pend_q || !tx_mode) ? PT_DATA : PT_ACK;

  assign set_bc   = rise_act & (cnt_nx == bc_pt);
  assign set_addr = set_bc & addr_pend_q;
  assign set_lrb  = rise_act & (cnt_nx == PT_ACK) & tx_mode & ~addr_pend_q;
  assign lrb_bit  = sda_f;
  assign set_stop = stop_q;
  assign set_berr = (start_q | stop_q) & active_q & (cnt_q >= PT_MID);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      addr_pend_q <= 1'b0;
      active_q    <= 1'b0;
    end else if (start_q) begin
      cnt_q       <= '0;
      addr_pend_q <= 1'b1;
      active_q    <= 1'b1;
    end else if (stop_q) begin
      cnt_q       <= '0;
      addr_pend_q <= 1'b0;
      active_q    <= 1'b0;
    end else if (rise_act) begin
      if (cnt_nx == PT_ACK) begin
        cnt_q       <= '0;
        addr_pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/i2c_stat_gen.sv
module i2c_stat_gen
  import i2c_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 1,
  parameter int BYTE_BITS   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic tx_mode_i,
  input  logic clr_i,
  output logic st_bc_o,
  output logic st_addr_o,
  output logic st_lrb_o,
  output logic st_stop_o,
  output logic st_berr_o,
  output logic lrb_val_o,
  output logic irq_o
);
  logic  scl_flt, sda_flt;
  logic  scl_rise, start_q, stop_q;
  logic  set_bc, set_addr, set_lrb, lrb_bit, set_stop, set_berr;
  stat_t stat_q, stat_nx;
  logic  lrb_val_q, irq_q;

  i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_scl_flt (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_flt)
  );

  i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_sda_flt (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_flt)
  );

  i2c_cond_detect u_det (
    .clk(clk), .rst(rst), .scl_f(scl_flt), .sda_f(sda_flt),
    .scl_rise(scl_rise), .start_q(start_q), .stop_q(stop_q)
  );

  i2c_bit_tracker #(.BYTE_BITS(BYTE_BITS)) u_trk (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .start_q(start_q), .stop_q(stop_q),
    .tx_mode(tx_mode_i), .sda_f(sda_flt),
    .set_bc(set_bc), .set_addr(set_addr), .set_lrb(set_lrb), .lrb_bit(lrb_bit),
    .set_stop(set_stop), .set_berr(set_berr)
  );

  always_comb begin
    stat_nx = clr_i ? '0 : stat_q;
    if (set_bc)   stat_nx.bc   = 1'b1;
    if (set_addr) stat_nx.addr = 1'b1;
    if (set_lrb)  stat_nx.lrb  = 1'b1;
    if (set_stop) stat_nx.stop = 1'b1;
    if (set_berr) stat_nx.berr = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q    <= '0;
      lrb_val_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      stat_q <= stat_nx;
      irq_q  <= |stat_nx;
      if (set_lrb) lrb_val_q <= lrb_bit;
    end
  end

  assign st_bc_o   = stat_q.bc;
  assign st_addr_o = stat_q.addr;
  assign st_lrb_o  = stat_q.lrb;
  assign st_stop_o = stat_q.stop;
  assign st_berr_o = stat_q.berr;
  assign lrb_val_o = lrb_val_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/i2c_stat_gen_chk.sv
module i2c_stat_gen_chk (
  input logic clk,
  input logic rst,
  input logic clr_i,
  input logic scl_f,
  input logic bc,
  input logic addr,
  input logic lrb,
  input logic stop,
  input logic berr,
  input logic irq
);
  logic any_st;
  assign any_st = bc | addr | lrb | stop | berr;

  AST_IRQ_WHEN_FLAG: assert property (@(posedge clk) disable iff (rst) any_st |-> irq); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst) !any_st |-> !irq); // R9
  AST_BC_STICKY: assert property (@(posedge clk) disable iff (rst) (bc && !clr_i) |=> bc); // R8
  AST_BERR_STICKY: assert property (@(posedge clk) disable iff (rst) (berr && !clr_i) |=> berr); // R8
  AST_ADDR_WITH_BC: assert property (@(posedge clk) disable iff (rst) (addr && !$past(addr)) |-> bc); // R4
  AST_LRB_WITH_BC: assert property (@(posedge clk) disable iff (rst) (lrb && !$past(lrb)) |-> bc); // R5
  AST_STOP_SCL_HIGH: assert property (@(posedge clk) disable iff (rst) (stop && !$past(stop)) |-> scl_f); // R6
endmodule

bind i2c_stat_gen i2c_stat_gen_chk u_chk (
  .clk(clk), .rst(rst), .clr_i(clr_i), .scl_f(scl_flt),
  .bc(st_bc_o), .addr(st_addr_o), .lrb(st_lrb_o), .stop(st_stop_o),
  .berr(st_berr_o), .irq(irq_o)
);

// File: tb/i2c_stat_gen_tb_top.sv
module i2c_stat_gen_tb_top;
  localparam int CLK_P = 10;
  localparam int HOLD  = 8;
  localparam int NVEC  = 7;
  // [14] start first, [13] tx mode, [12:5] byte, [4] ack bit,
  // [3] exp bc, [2] exp addr, [1] exp lrb flag, [0] exp lrb value
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'hA4, 1'b0, 4'b1100},
    {1'b0, 1'b0, 8'h5A, 1'b0, 4'b1000},
    {1'b0, 1'b1, 8'hC3, 1'b1, 4'b1011},
    {1'b0, 1'b1, 8'h3C, 1'b0, 4'b1010},
    {1'b1, 1'b1, 8'hA5, 1'b0, 4'b1100},
    {1'b0, 1'b1, 8'hFF, 1'b1, 4'b1011},
    {1'b1, 1'b0, 8'h00, 1'b0, 4'b1101}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_i = 1'b1, sda_i = 1'b1, tx_mode_i = 1'b0, clr_i = 1'b0;
  logic st_bc_o, st_addr_o, st_lrb_o, st_stop_o, st_berr_o, lrb_val_o, irq_o;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  i2c_stat_gen dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .tx_mode_i(tx_mode_i),
    .clr_i(clr_i), .st_bc_o(st_bc_o), .st_addr_o(st_addr_o), .st_lrb_o(st_lrb_o),
    .st_stop_o(st_stop_o), .st_berr_o(st_berr_o), .lrb_val_o(lrb_val_o), .irq_o(irq_o)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic set_bus(input logic c, input logic d);
    scl_i = c; sda_i = d;
    cyc(HOLD);
  endtask

  task automatic send_start();
    set_bus(1'b0, 1'b1); set_bus(1'b1, 1'b1); set_bus(1'b1, 1'b0); set_bus(1'b0, 1'b0);
  endtask

  task automatic send_stop();
    set_bus(1'b0, 1'b0); set_bus(1'b1, 1'b0); set_bus(1'b1, 1'b1);
  endtask

  task automatic send_bit(input logic b);
    set_bus(1'b0, b); set_bus(1'b1, b); set_bus(1'b0, b);
  endtask

  task automatic pulse_clr();
    clr_i = 1'b1; cyc(1); clr_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(4); rst = 1'b0; cyc(2);
    // R1 reset state
    chk("R1 bc", st_bc_o, 1'b0);   chk("R1 addr", st_addr_o, 1'b0);
    chk("R1 lrb", st_lrb_o, 1'b0); chk("R1 stop", st_stop_o, 1'b0);
    chk("R1 berr", st_berr_o, 1'b0); chk("R1 lrbv", lrb_val_o, 1'b0);
    chk("R1 irq", irq_o, 1'b0);

    // table walk: R2 R3 R4 R5 R11
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][14]) send_start();
      tx_mode_i = VEC[v][13];
      for (int b = 7; b >= 0; b--) send_bit(VEC[v][5 + b]);
      send_bit(VEC[v][4]);
      chk("R2/R3 bc", st_bc_o, VEC[v][3]);
      chk("R4 addr", st_addr_o, VEC[v][2]);
      chk("R5 lrb", st_lrb_o, VEC[v][1]);
      chk("R5 lrbv", lrb_val_o, VEC[v][0]);
      chk("R11 no berr", st_berr_o, 1'b0);
      pulse_clr();
    end
    send_stop(); pulse_clr(); cyc(2);

    // R2 exact edge on the 8th rise, R9 irq, R8 sticky and clear
    tx_mode_i = 1'b0;
    send_start();
    for (int b = 0; b < 7; b++) send_bit(1'b1);
    set_bus(1'b0, 1'b0);
    pulse_clr(); cyc(1);
    scl_i = 1'b1;
    cyc(4); chk("R2 bc before edge 5", st_bc_o, 1'b0);
    cyc(1); chk("R2 bc at edge 5", st_bc_o, 1'b1);
    chk("R9 irq follows", irq_o, 1'b1);
    chk("R4 addr at edge 5", st_addr_o, 1'b1);
    cyc(HOLD); set_bus(1'b0, 1'b0);
    send_bit(1'b0);
    chk("R8 bc sticky", st_bc_o, 1'b1);
    pulse_clr();
    chk("R8 bc cleared", st_bc_o, 1'b0);
    chk("R8 addr cleared", st_addr_o, 1'b0);
    chk("R9 irq low", irq_o, 1'b0);

    // R3 transmit: nothing at 8th rise, set at 9th
    tx_mode_i = 1'b1;
    for (int b = 0; b < 8; b++) send_bit(b[0]);
    chk("R3 no bc at 8th", st_bc_o, 1'b0);
    send_bit(1'b1);
    chk("R3 bc at 9th", st_bc_o, 1'b1);
    chk("R5 nack captured", lrb_val_o, 1'b1);
    pulse_clr();

    // R10 one-cycle glitch on SCL is not counted
    tx_mode_i = 1'b0;
    for (int b = 0; b < 7; b++) send_bit(1'b0);
    scl_i = 1'b1; cyc(1); scl_i = 1'b0; cyc(HOLD * 2);
    chk("R10 glitch ignored", st_bc_o, 1'b0);
    send_bit(1'b0);
    chk("R10 real 8th counted", st_bc_o, 1'b1);
    send_bit(1'b0);
    pulse_clr();

    // R7 misplaced START with exact timing
    for (int b = 0; b < 3; b++) send_bit(1'b1);
    set_bus(1'b0, 1'b1); set_bus(1'b1, 1'b1);
    sda_i = 1'b0;
    cyc(5); chk("R7 berr before edge 6", st_berr_o, 1'b0);
    cyc(1); chk("R7 berr misplaced start", st_berr_o, 1'b1);
    cyc(HOLD); set_bus(1'b0, 1'b0);
    pulse_clr();

    // R6 stop timing at a boundary, R7 no error there
    set_bus(1'b0, 1'b0); set_bus(1'b1, 1'b0);
    sda_i = 1'b1;
    cyc(5); chk("R6 stop before edge 6", st_stop_o, 1'b0);
    cyc(1); chk("R6 stop at edge 6", st_stop_o, 1'b1);
    chk("R7 boundary stop no berr", st_berr_o, 1'b0);
    cyc(HOLD); pulse_clr();

    // R2 idle clocks without START are not counted
    for (int b = 0; b < 9; b++) send_bit(1'b1);
    chk("R2 idle no bc", st_bc_o, 1'b0);

    // R7 misplaced STOP
    send_start();
    for (int b = 0; b < 4; b++) send_bit(1'b0);
    send_stop();
    chk("R7 berr misplaced stop", st_berr_o, 1'b1);
    chk("R6 stop flag", st_stop_o, 1'b1);
    chk("R5 lrbv kept over clears", lrb_val_o, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule